// File: doc/BRIEF.md
# Wormhole Output Port Arbiter

This block is the arbitration and forwarding stage of one output port in a router that uses wormhole switching. Each input port presents the head of a waiting packet as a valid character together with a one-bit urgency tag. The arbiter chooses one of these inputs and locks the output to it. It then passes that input's characters through one at a time until the character that closes the packet has been taken by the next hop. Inputs that lose stay blocked, and their characters remain in their own input buffers because the arbiter never grants them a ready.

The choice between inputs has two levels. Any urgent requester beats every normal one. Inside a level, a rotating pointer gives fair turns, and an input that has just been served falls to last place among its peers. Forwarding follows a valid/ready handshake on both sides. A downstream stall therefore holds the packet where it is and keeps the output reserved.

Top module: `wh_outport_arb`

## Requirements
- R1: While reset is active, and in the first cycle after it, no input is granted, out_valid is low and every in_ready bit is low.
- R2: When no input holds the output, the next clock edge grants exactly one input if at least one in_valid bit is high, and grants none if all are low. The grant vector is one-hot or zero at all times.
- R3: At arbitration, an input with in_valid high and in_prio high (urgent) always beats any input whose in_prio is low.
- R4: Each level has its own pointer, and both pointers are 0 after reset. The search starts at that level's pointer and goes upward with wrap-around. After a grant, the pointer of the winning level moves to the winner's index plus one, modulo the number of inputs.
- R5: While an input is granted, out_valid and out_char equal that input's in_valid and in_char, and that input's in_ready equals out_ready.
- R6: An input that is not granted sees in_ready low, whatever its in_valid.
- R7: A character has data in bits 7:0 and the end-of-packet flag in bit 8. Once granted, the grant stays unchanged until a character with bit 8 set is accepted (out_valid and out_ready both high). A new urgent request does not break the lock.
- R8: On the edge that accepts the end-of-packet character, the grant is cleared. The output is then free for the following cycle, and a new winner may be granted on the next edge.
- R9: While out_ready is low, no input sees in_ready high. The presented character stays on out_char, and the grant is kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | NUM_IN | Per input: a character is presented (request) |
| in_prio | input | NUM_IN | Per input: 1 = urgent level, 0 = normal level |
| in_char | input | NUM_IN*9 | Per input character, input p in bits [p*9 +: 9] |
| in_ready | output | NUM_IN | Per input: character taken this cycle |
| out_valid | output | 1 | Character presented to the next hop |
| out_char | output | 9 | Forwarded character, bit 8 = end of packet |
| out_ready | input | 1 | Next hop accepts a character |
| grant | output | NUM_IN | One-hot owner of the output, zero when free |

## Verification
The properties assume that a source follows the valid/ready rules: once it raises in_valid, it keeps the same character and urgency tag until the character is taken. They also assume that a source drops in_valid after its end-of-packet character is taken, unless another packet is queued behind it. The stimulus changes inputs only at falling edges. It removes a losing requester only while another input holds the output, so no property ever sees a request withdrawn during an arbitration cycle. Expected winners come from a hand-worked sequence of pointer positions that starts from reset. The packet-level tests hold characters steady across every stall.

// File: rtl/wh_arb_pkg.sv
package wh_arb_pkg;
    // width of the data part of one character
    parameter int unsigned DATA_W = 8;
    // a character carries the data plus one end-of-packet flag on top
    localparam int unsigned CHAR_W  = DATA_W + 1;
    localparam int unsigned EOP_POS = DATA_W;
endpackage

// File: rtl/wh_rr_pick.sv
// Rotating first-match search: lowest index at or above start, with wrap.
module wh_rr_pick #(
    parameter int unsigned N = 4,
    localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    input  logic [IW-1:0] start,
    output logic          hit,
    output logic [IW-1:0] idx
);
    logic [IW:0] pos;

    always_comb begin
        hit = 1'b0;
        idx = '0;
        pos = '0;
        for (int k = 0; k < int'(N); k++) begin
            pos = {1'b0, start} + (IW+1)'(k);
            if (pos >= (IW+1)'(N)) begin
                pos = pos - (IW+1)'(N);
            end
            if (!hit && req[pos[IW-1:0]]) begin
                hit = 1'b1;
                idx = pos[IW-1:0];
            end
        end
    end
endmodule

// File: rtl/wh_char_mux.sv
// Selects the owner's character and valid onto the output side.
module wh_char_mux #(
    parameter int unsigned N = 4,
    parameter int unsigned W = 9,
    localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N*W-1:0] chars,
    input  logic [N-1:0]   valids,
    input  logic [IW-1:0]  sel,
    input  logic           en,
    output logic           sel_valid,
    output logic [W-1:0]   sel_char
);
    always_comb begin
        sel_valid = en & valids[sel];
        sel_char  = chars[sel*W +: W];
    end
endmodule

// File: rtl/wh_outport_arb.sv
module wh_outport_arb
    import wh_arb_pkg::*;
#(
    parameter int unsigned NUM_IN = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_IN-1:0]        in_valid,
    input  logic [NUM_IN-1:0]        in_prio,
    input  logic [NUM_IN*CHAR_W-1:0] in_char,
    output logic [NUM_IN-1:0]        in_ready,
    output logic                     out_valid,
    output logic [CHAR_W-1:0]        out_char,
    input  logic                     out_ready,
    output logic [NUM_IN-1:0]        grant
);
    localparam int unsigned IW     = (NUM_IN > 1) ? $clog2(NUM_IN) : 1;
    localparam int unsigned LEVELS = 2;
    localparam int unsigned LVL_HI = 1;
    localparam int unsigned LVL_LO = 0;

    typedef struct packed {
        logic          locked;
        logic [IW-1:0] owner;
        logic [IW-1:0] ptr_hi;
        logic [IW-1:0] ptr_lo;
    } arb_state_t;

    arb_state_t st_d, st_q;

    logic [NUM_IN-1:0] lvl_req [LEVELS];
    logic [IW-1:0]     lvl_ptr [LEVELS];
    logic [IW-1:0]     lvl_idx [LEVELS];
    logic [LEVELS-1:0] lvl_hit;
    logic              eop_taken;

    function automatic logic [IW-1:0] wrap_inc(input logic [IW-1:0] v);
        return (v == IW'(NUM_IN - 1)) ? '0 : v + 1'b1;
    endfunction

    // request split per urgency level
    always_comb begin
        lvl_req[LVL_HI] = in_valid & in_prio;
        lvl_req[LVL_LO] = in_valid & ~in_prio;
        lvl_ptr[LVL_HI] = st_q.ptr_hi;
        lvl_ptr[LVL_LO] = st_q.ptr_lo;
    end

    for (genvar g = 0; g < LEVELS; g++) begin : g_level
        wh_rr_pick #(.N(NUM_IN)) u_pick (
            .req   (lvl_req[g]),
            .start (lvl_ptr[g]),
            .hit   (lvl_hit[g]),
            .idx   (lvl_idx[g])
        );
    end

    wh_char_mux #(.N(NUM_IN), .W(CHAR_W)) u_mux (
        .chars     (in_char),
        .valids    (in_valid),
        .sel       (st_q.owner),
        .en        (st_q.locked),
        .sel_valid (out_valid),
        .sel_char  (out_char)
    );

    for (genvar p = 0; p < NUM_IN; p++) begin : g_port
        assign grant[p]    = st_q.locked && (st_q.owner == IW'(p));
        assign in_ready[p] = grant[p] & out_ready;
    end

    assign eop_taken = out_valid & out_ready & out_char[EOP_POS];

    always_comb begin
        st_d = st_q;
        if (st_q.locked) begin
            if (eop_taken) begin
                st_d.locked = 1'b0;
            end
        end else if (lvl_hit[LVL_HI]) begin
            st_d.locked = 1'b1;
            st_d.owner  = lvl_idx[LVL_HI];
            st_d.ptr_hi = wrap_inc(lvl_idx[LVL_HI]);
        end else if (lvl_hit[LVL_LO]) begin
            st_d.locked = 1'b1;
            st_d.owner  = lvl_idx[LVL_LO];
            st_d.ptr_lo = wrap_inc(lvl_idx[LVL_LO]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/wh_arb_chk.sv
module wh_arb_chk
    import wh_arb_pkg::*;
#(
    parameter int unsigned NUM_IN = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_IN-1:0]   in_valid,
    input logic [NUM_IN-1:0]   in_prio,
    input logic [NUM_IN-1:0]   in_ready,
    input logic                out_valid,
    input logic [CHAR_W-1:0]   out_char,
    input logic                out_ready,
    input logic [NUM_IN-1:0]   grant
);
    // R2
    one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R2
    grant_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant == '0 && in_valid != '0) |=> (grant != '0));

    // R2
    no_idle_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant == '0 && in_valid == '0) |=> (grant == '0));

    // R3
    urgent_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant == '0 && (in_valid & in_prio) != '0) |=> ((grant & $past(in_prio)) != '0));

    // R5
    out_needs_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (grant != '0));

    // R6
    blocked_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((in_ready & ~grant) == '0));

    // R7
    hold_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant != '0 && !(out_valid && out_ready && out_char[EOP_POS])) |=> $stable(grant));

    // R8
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_char[EOP_POS]) |=> (grant == '0));

    // R9
    stall_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready != '0) |-> out_ready);
endmodule

bind wh_outport_arb wh_arb_chk #(.NUM_IN(NUM_IN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_prio   (in_prio),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_char  (out_char),
    .out_ready (out_ready),
    .grant     (grant)
);

// File: tb/sim_wh_outport_arb.sv
module sim_wh_outport_arb;
    import wh_arb_pkg::*;

    localparam int unsigned NUM_IN = 4;
    localparam int unsigned NVEC   = 10;

    logic                     clk = 1'b0;
    logic                     rst_n;
    logic [NUM_IN-1:0]        in_valid;
    logic [NUM_IN-1:0]        in_prio;
    logic [NUM_IN*CHAR_W-1:0] in_char;
    logic [NUM_IN-1:0]        in_ready;
    logic                     out_valid;
    logic [CHAR_W-1:0]        out_char;
    logic                     out_ready;
    logic [NUM_IN-1:0]        grant;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // {request mask, urgency mask, expected winner}; pointers start at 0
    localparam logic [9:0] VEC [NVEC] = '{
        {4'b1111, 4'b0000, 2'd0},
        {4'b1111, 4'b0000, 2'd1},
        {4'b0011, 4'b0000, 2'd0},
        {4'b1010, 4'b1000, 2'd3},
        {4'b1111, 4'b0110, 2'd1},
        {4'b1111, 4'b0110, 2'd2},
        {4'b1111, 4'b0110, 2'd1},
        {4'b1100, 4'b0000, 2'd2},
        {4'b0001, 4'b0001, 2'd0},
        {4'b1001, 4'b0000, 2'd3}
    };

    always #2 clk = ~clk;

    wh_outport_arb #(.NUM_IN(NUM_IN)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_prio   (in_prio),
        .in_char   (in_char),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .out_char  (out_char),
        .out_ready (out_ready),
        .grant     (grant)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic put_char(input int p, input logic eop, input logic [7:0] d);
        in_char[p*CHAR_W +: CHAR_W] = {eop, d};
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R2 watchdog: actual hung expected finished");
            finish_run();
        end
    end

    initial begin
        rst_n     = 1'b0;
        in_valid  = '1;
        in_prio   = '0;
        in_char   = '0;
        out_ready = 1'b1;
        for (int p = 0; p < NUM_IN; p++) put_char(p, 1'b1, 8'h40);
        repeat (3) @(negedge clk);
        // R1: requests during reset are ignored
        chk("R1 grant in reset", 32'(grant), 32'h0);
        chk("R1 out_valid in reset", 32'(out_valid), 32'h0);
        chk("R1 in_ready in reset", 32'(in_ready), 32'h0);
        in_valid = '0;
        rst_n    = 1'b1;
        @(negedge clk);
        chk("R1 grant after reset", 32'(grant), 32'h0);

        // table of single-character packets
        for (int v = 0; v < int'(NVEC); v++) begin
            logic [3:0] mask;
            logic [3:0] prio;
            logic [1:0] win;
            {mask, prio, win} = VEC[v];
            in_valid  = mask;
            in_prio   = prio;
            out_ready = 1'b1;
            for (int p = 0; p < NUM_IN; p++) put_char(p, 1'b1, 8'(8'h10 + p));
            @(negedge clk);
            // R3 R4: winner by urgency then rotating pointer
            chk("R3 R4 winner", 32'(grant), 32'(1 << win));
            // R5
            chk("R5 forwarded char", 32'(out_char), 32'({1'b1, 8'(8'h10 + win)}));
            // R6
            chk("R6 ready only to owner", 32'(in_ready), 32'(1 << win));
            in_valid = grant;
            @(negedge clk);
            // R8
            chk("R8 free after end flag", 32'(grant), 32'h0);
            in_valid = '0;
        end

        // multi-character packet with stalls; pointers now hi=1, lo=0
        @(negedge clk);
        in_prio   = '0;
        out_ready = 1'b0;
        in_valid  = 4'b0100;
        put_char(2, 1'b0, 8'hA1);
        @(negedge clk);
        chk("R2 single requester granted", 32'(grant), 32'h4);
        chk("R9 no ready while stalled", 32'(in_ready), 32'h0);
        chk("R5 out_valid follows owner", 32'(out_valid), 32'h1);
        in_valid = 4'b1110;
        in_prio  = 4'b1000;
        put_char(1, 1'b1, 8'h55);
        put_char(3, 1'b1, 8'h77);
        @(negedge clk);
        // R7: urgent arrival does not break the lock; R9: char held
        chk("R7 lock held against urgent", 32'(grant), 32'h4);
        chk("R9 char held in stall", 32'(out_char), 32'({1'b0, 8'hA1}));
        chk("R6 waiting inputs blocked", 32'(in_ready), 32'h0);
        out_ready = 1'b1;
        #1;
        chk("R5 owner ready follows out_ready", 32'(in_ready), 32'h4);
        @(negedge clk);
        put_char(2, 1'b0, 8'hB2);
        #1;
        chk("R7 lock held mid packet", 32'(grant), 32'h4);
        chk("R5 second char", 32'(out_char), 32'({1'b0, 8'hB2}));
        @(negedge clk);
        put_char(2, 1'b1, 8'hC3);
        @(negedge clk);
        chk("R8 release on end flag", 32'(grant), 32'h0);
        chk("R8 idle out_valid", 32'(out_valid), 32'h0);
        in_valid = 4'b1010;
        @(negedge clk);
        chk("R3 urgent waiter wins", 32'(grant), 32'h8);
        chk("R5 urgent char", 32'(out_char), 32'({1'b1, 8'h77}));
        @(negedge clk);
        chk("R8 release after urgent", 32'(grant), 32'h0);
        in_valid = 4'b0010;
        @(negedge clk);
        chk("R4 normal waiter next", 32'(grant), 32'h2);
        @(negedge clk);
        in_valid = '0;
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            chk("R2 no request no grant", 32'(grant), 32'h0);
            chk("R2 idle output", 32'(out_valid), 32'h0);
        end
        finish_run();
    end
endmodule